// File: doc/BRIEF.md
# Pending-Bit Resolving Bitstream Emitter

This block is the last stage of a binary arithmetic coding pipeline. For every coded bin the earlier stages hand it the seven most significant bits of the coder's low register, the number of outstanding bits whose polarity was still undecided, and the number of bits that became definite. The block resolves the outstanding bits in one step and emits a left-aligned output word with a count of how many leading bits of that word are meaningful. Because the outstanding bits are always the inverse of the leading low bit, they are produced by replication rather than held in a FIFO or memory.

The result is registered: one cycle after an accepted input the word, the count and an output strobe appear. Without an input strobe the outputs keep their last value. A downstream packer consumes the count and the leading word bits; it is not part of this block.

Top module: `bsg_emit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_word`, `out_cnt` and `out_valid` become all zeros.
- R2: With `in_valid` high and `pend_cnt` = 0 and a non-zero total count, `out_word` one cycle later is `low_top[6:0]` in bits 31 down to 25, with bits 24 down to 0 zero.
- R3: With `in_valid` high and `pend_cnt` = k (1..31) and a non-zero total count, `out_word` one cycle later holds, from bit 31 downward, `low_top[6]`, then k copies of the inverse of `low_top[6]`, then `low_top[5:0]`, then zeros; bits that would fall below bit 0 are dropped, so k = 31 fills the word with `low_top[6]` and 31 inverted copies.
- R4: With `in_valid` high, `out_cnt` one cycle later equals `det_cnt + pend_cnt`, saturated at 32.
- R5: With `in_valid` high and `det_cnt + pend_cnt` = 0, one cycle later `out_cnt` is 0 and `out_word` is all zeros.
- R6: While `in_valid` is low, `out_word` and `out_cnt` keep their values whatever `low_top`, `pend_cnt` and `det_cnt` do, and `out_valid` is low one cycle later.
- R7: `out_valid` is high in the cycle after each cycle in which `in_valid` was high (one-cycle latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the per-bin inputs |
| low_top | input | 7 | Seven most significant bits of the coder low register |
| pend_cnt | input | 5 | Outstanding bits to resolve (0..31) |
| det_cnt | input | 4 | Bits determined for this bin |
| out_valid | output | 1 | Output word and count are fresh |
| out_word | output | 32 | Left-aligned emitted bits |
| out_cnt | output | 6 | Number of meaningful leading bits of out_word (0..32) |

## Verification
The bench sweeps every outstanding-bit count from 0 to 31 with random low values of both leading polarities, so a design that copies the leading bit instead of inverting it, or misplaces the tail six bits by one position, shows a wrong word. At 31 outstanding bits the tail must fall entirely off the word; a design that wraps or keeps the tail would corrupt the low-order positions. Totals above 32 catch a count that wraps instead of saturating, a zero total catches a word left non-zero, and idle cycles with changing inputs catch registers that load without the strobe.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
  // Width of the low-register slice handed over per bin.
  localparam int LOW_BITS = 7;
  typedef logic [LOW_BITS-1:0] low_slice_t;
endpackage

// File: rtl/bsg_word_build.sv
module bsg_word_build
  import bsg_pkg::*;
#(
  parameter int W      = 32,
  parameter int PEND_W = $clog2(W)
) (
  input  low_slice_t        low_i,
  input  logic [PEND_W-1:0] pend_i,
  output logic [W-1:0]      word_o
);
  localparam int TAIL_BITS = LOW_BITS - 1;

  logic              lead;
  logic [PEND_W:0]   head_len;
  logic [W-1:0]      head_mask;
  logic [W-1:0]      head_bits;
  logic [W-1:0]      tail_bits;

  assign lead      = low_i[LOW_BITS-1];
  // Leading bit plus pend_i resolved copies occupy the top head_len positions.
  assign head_len  = {1'b0, pend_i} + {{PEND_W{1'b0}}, 1'b1};
  assign head_mask = ~({W{1'b1}} >> head_len);
  assign head_bits = {lead, {(W-1){~lead}}} & head_mask;
  // The remaining low bits follow directly below the head; overflow drops off.
  assign tail_bits = {low_i[TAIL_BITS-1:0], {(W-TAIL_BITS){1'b0}}} >> head_len;
  assign word_o    = head_bits | tail_bits;
endmodule

// File: rtl/bsg_count_sat.sv
module bsg_count_sat #(
  parameter int W      = 32,
  parameter int PEND_W = $clog2(W),
  parameter int DET_W  = 4,
  parameter int CNT_W  = $clog2(W + 1)
) (
  input  logic [PEND_W-1:0] pend_i,
  input  logic [DET_W-1:0]  det_i,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int SUM_W = ((PEND_W > DET_W) ? PEND_W : DET_W) + 2;

  logic [SUM_W-1:0] total;

  assign total = SUM_W'(pend_i) + SUM_W'(det_i);
  assign cnt_o = (total > SUM_W'(W)) ? CNT_W'(W) : total[CNT_W-1:0];
endmodule

// File: rtl/bsg_emit.sv
module bsg_emit
  import bsg_pkg::*;
#(
  parameter int W      = 32,
  parameter int DET_W  = 4,
  parameter int PEND_W = $clog2(W),
  parameter int CNT_W  = $clog2(W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [LOW_BITS-1:0] low_top,
  input  logic [PEND_W-1:0] pend_cnt,
  input  logic [DET_W-1:0]  det_cnt,
  output logic              out_valid,
  output logic [W-1:0]      out_word,
  output logic [CNT_W-1:0]  out_cnt
);
  localparam int SUM_W = ((PEND_W > DET_W) ? PEND_W : DET_W) + 2;

  logic [W-1:0]     built_word;
  logic [CNT_W-1:0] sat_cnt;

  bsg_word_build #(.W(W), .PEND_W(PEND_W)) word_u (
    .low_i  (low_top),
    .pend_i (pend_cnt),
    .word_o (built_word)
  );

  bsg_count_sat #(.W(W), .PEND_W(PEND_W), .DET_W(DET_W), .CNT_W(CNT_W)) cnt_u (
    .pend_i (pend_cnt),
    .det_i  (det_cnt),
    .cnt_o  (sat_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_cnt   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_cnt  <= sat_cnt;
        out_word <= (sat_cnt == '0) ? '0 : built_word;
      end
    end
  end

  // R4
  cnt_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    out_cnt <= CNT_W'(W));

  // R5
  empty_word_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && (SUM_W'(pend_cnt) + SUM_W'(det_cnt) == '0) |=> out_word == '0);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_word) && $stable(out_cnt) && !out_valid);

  // R7
  strobe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R3
  lead_bit_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && (SUM_W'(pend_cnt) + SUM_W'(det_cnt) != '0)
    |=> out_word[W-1] == $past(low_top[LOW_BITS-1]));

  // R3
  resolved_flip_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && (pend_cnt != '0) && (SUM_W'(pend_cnt) + SUM_W'(det_cnt) != '0)
    |=> out_word[W-1] != out_word[W-2]);
endmodule

// File: tb/bsg_emit_tb_top.sv
module bsg_emit_tb_top;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [6:0]  low_top = '0;
  logic [4:0]  pend_cnt = '0;
  logic [3:0]  det_cnt = '0;
  logic        out_valid;
  logic [31:0] out_word;
  logic [5:0]  out_cnt;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  bsg_emit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .low_top(low_top),
    .pend_cnt(pend_cnt), .det_cnt(det_cnt),
    .out_valid(out_valid), .out_word(out_word), .out_cnt(out_cnt)
  );

  function automatic logic [31:0] model_word(logic [6:0] lo, int pend, int det);
    logic [31:0] w;
    int pos;
    w = '0;
    if (pend + det == 0) return w;
    pos = 31;
    w[pos] = lo[6]; pos--;
    for (int k = 0; k < pend; k++) begin
      if (pos >= 0) w[pos] = ~lo[6];
      pos--;
    end
    for (int k = 5; k >= 0; k--) begin
      if (pos >= 0) w[pos] = lo[k];
      pos--;
    end
    return w;
  endfunction

  function automatic int model_cnt(int pend, int det);
    return (pend + det > W) ? W : pend + det;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one bin and check the registered result.
  task automatic apply(logic [6:0] lo, int pend, int det, string req);
    @(negedge clk);
    low_top  = lo;
    pend_cnt = pend[4:0];
    det_cnt  = det[3:0];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " word"}, 64'(out_word), 64'(model_word(lo, pend, det)));
    check("R4 count", 64'(out_cnt), 64'(model_cnt(pend, det)));
    check("R7 strobe", 64'(out_valid), 64'd1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 word", 64'(out_word), 64'd0);
    check("R1 count", 64'(out_cnt), 64'd0);
    check("R1 strobe", 64'(out_valid), 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_no_pending();
    apply(7'b1011001, 0, 3, "R2");
    apply(7'b0100110, 0, 1, "R2");
    apply(7'b1111111, 0, 15, "R2");
  endtask

  task automatic t_sweep();
    for (int p = 0; p < 32; p++) begin
      apply(7'($urandom), p, 1 + int'($urandom % 15), "R3");
      apply({1'b0, 6'($urandom)}, p, 1, "R3");
      apply({1'b1, 6'($urandom)}, p, 2, "R3");
    end
    apply(7'b0101010, 31, 1, "R3 full");
    check("R3 full explicit", 64'(out_word), 64'h7FFF_FFFF);
  endtask

  task automatic t_saturate();
    apply(7'b1000001, 31, 15, "R4 sat");
    apply(7'b0000001, 17, 15, "R4 sat");
    apply(7'b0110011, 20, 12, "R4 edge");
    apply(7'b0110011, 20, 13, "R4 over");
  endtask

  task automatic t_zero_total();
    apply(7'b1111111, 5, 4, "R5 prep");
    apply(7'b1111111, 0, 0, "R5");
    check("R5 explicit zero", 64'(out_word), 64'd0);
  endtask

  task automatic t_idle_hold();
    logic [31:0] w0;
    logic [5:0]  c0;
    apply(7'b1100101, 4, 6, "R6 prep");
    w0 = out_word;
    c0 = out_cnt;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      low_top  = 7'($urandom);
      pend_cnt = 5'($urandom);
      det_cnt  = 4'($urandom);
      check("R6 word", 64'(out_word), 64'(w0));
      check("R6 count", 64'(out_cnt), 64'(c0));
      check("R6 strobe", 64'(out_valid), 64'd0);
    end
  endtask

  initial begin
    t_reset();
    t_no_pending();
    t_sweep();
    t_saturate();
    t_zero_total();
    t_idle_hold();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule